// File: doc/BRIEF.md
# Banked GPIO Register Controller

This block is the register side of a general-purpose I/O controller for up to 160 pins, grouped into five banks of 32. A single 32-bit register bus with separate read and write strobes reaches every bank. Each bank keeps its own pin directions, driven output levels, rising-edge and falling-edge enables, and an interrupt status word. It also returns the synchronized pad levels. The block drives the pad output-enable and output-value vectors. It passes the edge enables and the status word on to a companion block, which detects edges and reports them back as one-cycle event pulses.

Software changes output levels and edge enables through paired write-one-to-set and write-one-to-clear registers. A single pin can therefore change without a read-modify-write sequence. A direct write to the output register also works. A global register below the first bank holds one enable bit for each group of 16 pins. That word goes out to the interrupt routing logic. Reads are combinational and valid in the cycle the read strobe is high. Writes take effect at the next rising clock edge.

Top module: `gpio_regfile`

## Requirements
- R1: After reset every direction bit is 1, so every pin is an input and `pad_oe_o` is all zero. Outputs, edge enables, status bits and the group enable word are all zero.
- R2: The direction register is at bank offset 0x00. A bit value of 1 makes that pin an input, and 0 makes it an output. `pad_oe_o` for a pin is the inverse of its direction bit, and a read returns the stored direction.
- R3: Writing the output register at bank offset 0x04 replaces the driven levels on `pad_out_o` from the next clock edge. A read returns the levels being driven.
- R4: Writing the set register at bank offset 0x08 forces to 1 each output bit where the write data is 1, and leaves the other bits alone. A read of it returns the output levels.
- R5: Writing the clear register at bank offset 0x0C forces to 0 each output bit where the write data is 1, and leaves the other bits alone. A read of it returns the output levels.
- R6: A read of the input register at bank offset 0x10 returns the pad level through a two-flop synchronizer. A pad change shows after two rising edges and not after one, whatever the pin's direction. Writes to this register have no effect.
- R7: Rising-edge enables are set by write-one at bank offset 0x14 and cleared by write-one at 0x18. They appear on `rise_en_o`, and both offsets read back the enables.
- R8: Falling-edge enables are set by write-one at bank offset 0x1C and cleared by write-one at 0x20. They appear on `fall_en_o`, and both offsets read back the enables.
- R9: The status register is at bank offset 0x24. A pulse on `irq_evt_i` sets the bit for that pin, and a write of 1 clears it. When a pulse and a clear hit the same bit in the same cycle, the bit stays set.
- R10: Bank n starts at byte address 0x10 + 0x28*n, for n from 0 to 4, and serves pins 32n to 32n+31.
- R11: The group enable register at byte address 0x08 holds 10 bits, one for each 16-pin group. A read returns them in bits 9:0, with the upper write bits dropped, and they drive `grp_en_o`.
- R12: Reads of unmapped or misaligned addresses return zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_wr_i | input | 1 | Write strobe, one write per cycle |
| bus_rd_i | input | 1 | Read strobe |
| bus_addr_i | input | 8 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, zero when no read or unmapped |
| pad_in_i | input | 160 | Raw pad levels |
| pad_oe_o | output | 160 | Pad output enable, 1 drives |
| pad_out_o | output | 160 | Pad output level |
| rise_en_o | output | 160 | Rising-edge enables to the edge detector |
| fall_en_o | output | 160 | Falling-edge enables to the edge detector |
| irq_evt_i | input | 160 | Edge event pulses from the edge detector |
| irq_stat_o | output | 160 | Latched interrupt status |
| grp_en_o | output | 10 | Group interrupt enables |

## Verification
Every register bit that is stored reaches a pad, an enable vector or the status vector, so a wrong bit shows at the ports one clock after the write that caused it. A decode error shows up as a change in a bank or pin group that the write did not address. It also shows up as a nonzero read from a hole in the map. A synchronizer with the wrong depth shows up only in input-register reads, taken one and two edges after a pad change. A wrong priority between set and clear on a status bit shows up only when the event pulse and the clear arrive in the same cycle.

// File: rtl/gpio_regfile_pkg.sv
package gpio_regfile_pkg;
  typedef enum logic [3:0] {
    RG_DIR  = 4'd0,
    RG_OUT  = 4'd1,
    RG_SET  = 4'd2,
    RG_CLR  = 4'd3,
    RG_IN   = 4'd4,
    RG_SETR = 4'd5,
    RG_CLRR = 4'd6,
    RG_SETF = 4'd7,
    RG_CLRF = 4'd8,
    RG_STAT = 4'd9
  } reg_idx_e;

  localparam int REGS_PER_BANK = 10;
  localparam int REG_BYTES     = 4;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;

  // cycles since reset, saturating, so the delay check never looks before reset
  logic [1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  p_two_stage_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 2'd2) |-> (q_o == $past(d_i, 2)));
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_regfile_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  reg_idx_e     idx_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] rdata_o,
  input  logic [W-1:0] pin_i,
  input  logic [W-1:0] evt_i,
  output logic [W-1:0] dir_o,
  output logic [W-1:0] out_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o,
  output logic [W-1:0] stat_o
);
  logic [W-1:0] dir_q, out_q, rise_q, fall_q, stat_q;
  logic [W-1:0] stat_clr;

  assign stat_clr = (wr_i && idx_i == RG_STAT) ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q  <= '1;
      out_q  <= '0;
      rise_q <= '0;
      fall_q <= '0;
      stat_q <= '0;
    end else begin
      if (wr_i) begin
        unique case (idx_i)
          RG_DIR:  dir_q  <= wdata_i;
          RG_OUT:  out_q  <= wdata_i;
          RG_SET:  out_q  <= out_q | wdata_i;
          RG_CLR:  out_q  <= out_q & ~wdata_i;
          RG_SETR: rise_q <= rise_q | wdata_i;
          RG_CLRR: rise_q <= rise_q & ~wdata_i;
          RG_SETF: fall_q <= fall_q | wdata_i;
          RG_CLRF: fall_q <= fall_q & ~wdata_i;
          default: ;
        endcase
      end
      // event wins over a same-cycle clear
      stat_q <= (stat_q & ~stat_clr) | evt_i;
    end
  end

  always_comb begin
    unique case (idx_i)
      RG_DIR:                  rdata_o = dir_q;
      RG_OUT, RG_SET, RG_CLR:  rdata_o = out_q;
      RG_IN:                   rdata_o = pin_i;
      RG_SETR, RG_CLRR:        rdata_o = rise_q;
      RG_SETF, RG_CLRF:        rdata_o = fall_q;
      RG_STAT:                 rdata_o = stat_q;
      default:                 rdata_o = '0;
    endcase
  end

  assign dir_o  = dir_q;
  assign out_o  = out_q;
  assign rise_o = rise_q;
  assign fall_o = fall_q;
  assign stat_o = stat_q;

  p_set_only_adds_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && idx_i == RG_SET) |=> ((out_o & $past(out_o)) == $past(out_o)));
  p_clr_only_removes_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && idx_i == RG_CLR) |=> ((out_o & ~$past(out_o)) == '0));
  p_rise_cleared_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && idx_i == RG_CLRR) |=> ((rise_o & $past(wdata_i)) == '0));
  p_fall_cleared_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && idx_i == RG_CLRF) |=> ((fall_o & $past(wdata_i)) == '0));
  p_evt_sticks_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i != '0) |=> ((stat_o & $past(evt_i)) == $past(evt_i)));
  p_stat_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && evt_i == '0) |=> $stable(stat_o));
  p_in_ro_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && idx_i == RG_IN) |=> ($stable(dir_o) && $stable(out_o) && $stable(rise_o) && $stable(fall_o)));
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_regfile_pkg::*;
#(
  parameter int NBANK     = 5,
  parameter int BANK_W    = 32,
  parameter int GRP_PINS  = 16,
  parameter int ADDR_W    = 8,
  parameter int GRP_ADDR  = 8,
  parameter int BANK_BASE = 16,
  localparam int NPIN     = NBANK * BANK_W,
  localparam int NGRP     = NPIN / GRP_PINS,
  localparam int STRIDE   = REGS_PER_BANK * REG_BYTES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  input  logic [NPIN-1:0]   pad_in_i,
  output logic [NPIN-1:0]   pad_oe_o,
  output logic [NPIN-1:0]   pad_out_o,
  output logic [NPIN-1:0]   rise_en_o,
  output logic [NPIN-1:0]   fall_en_o,
  input  logic [NPIN-1:0]   irq_evt_i,
  output logic [NPIN-1:0]   irq_stat_o,
  output logic [NGRP-1:0]   grp_en_o
);
  logic [NPIN-1:0]               pin_sync;
  logic [NPIN-1:0]               dir_all;
  logic [NBANK-1:0]              bank_hit;
  logic [NBANK-1:0][BANK_W-1:0]  bank_rdata;
  logic                          aligned, grp_hit;
  logic [NGRP-1:0]               grp_q;

  assign aligned = (bus_addr_i[1:0] == 2'b00);
  assign grp_hit = (bus_addr_i == ADDR_W'(GRP_ADDR));

  gpio_sync #(.W(NPIN)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pad_in_i),
    .q_o   (pin_sync)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    localparam logic [ADDR_W-1:0] LO = ADDR_W'(BANK_BASE + b * STRIDE);
    localparam logic [ADDR_W-1:0] HI = ADDR_W'(BANK_BASE + (b + 1) * STRIDE);
    reg_idx_e idx;

    assign bank_hit[b] = aligned && (bus_addr_i >= LO) && (bus_addr_i < HI);
    assign idx         = reg_idx_e'(4'((bus_addr_i - LO) >> 2));

    gpio_bank #(.W(BANK_W)) u_bank (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_i   (bus_wr_i && bank_hit[b]),
      .idx_i  (idx),
      .wdata_i(bus_wdata_i[BANK_W-1:0]),
      .rdata_o(bank_rdata[b]),
      .pin_i  (pin_sync[b*BANK_W +: BANK_W]),
      .evt_i  (irq_evt_i[b*BANK_W +: BANK_W]),
      .dir_o  (dir_all[b*BANK_W +: BANK_W]),
      .out_o  (pad_out_o[b*BANK_W +: BANK_W]),
      .rise_o (rise_en_o[b*BANK_W +: BANK_W]),
      .fall_o (fall_en_o[b*BANK_W +: BANK_W]),
      .stat_o (irq_stat_o[b*BANK_W +: BANK_W])
    );
  end

  assign pad_oe_o = ~dir_all;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 grp_q <= '0;
    else if (bus_wr_i && grp_hit) grp_q <= bus_wdata_i[NGRP-1:0];
  end
  assign grp_en_o = grp_q;

  always_comb begin
    bus_rdata_o = '0;
    if (bus_rd_i) begin
      if (grp_hit) bus_rdata_o = 32'(grp_q);
      for (int b = 0; b < NBANK; b++)
        if (bank_hit[b]) bus_rdata_o = bus_rdata_o | 32'(bank_rdata[b]);
    end
  end

  p_one_target_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({grp_hit, bank_hit}));
  p_hole_reads_zero_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rd_i && !grp_hit && bank_hit == '0) |-> (bus_rdata_o == '0));
  p_hole_write_inert_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && !grp_hit && bank_hit == '0) |=> ($stable(pad_oe_o) && $stable(pad_out_o) && $stable(grp_en_o)));
  p_grp_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_wr_i && grp_hit) |=> $stable(grp_en_o));
endmodule

// File: tb/gpio_regfile_test.sv
module gpio_regfile_test;
  localparam int CLK_P = 10;
  localparam int NBANK = 5;
  localparam int NPIN  = 160;
  localparam int NGRP  = 10;

  logic             clk, rst_n;
  logic             bus_wr, bus_rd;
  logic [7:0]       bus_addr;
  logic [31:0]      bus_wdata, bus_rdata;
  logic [NPIN-1:0]  pad_in, pad_oe, pad_out, rise_en, fall_en, irq_evt, irq_stat;
  logic [NGRP-1:0]  grp_en;

  gpio_regfile uut (
    .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(bus_wr), .bus_rd_i(bus_rd),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .pad_in_i(pad_in), .pad_oe_o(pad_oe), .pad_out_o(pad_out),
    .rise_en_o(rise_en), .fall_en_o(fall_en), .irq_evt_i(irq_evt),
    .irq_stat_o(irq_stat), .grp_en_o(grp_en)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  int total = 0;
  int bad   = 0;

  logic [NPIN-1:0] m_dir, m_out, m_rise, m_fall, m_stat, m_pin;
  logic [NGRP-1:0] m_grp;

  task automatic chk(string req, logic [NPIN-1:0] act, logic [NPIN-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic void mwr(logic [7:0] a, logic [31:0] d, logic [NPIN-1:0] ev);
    int b, r;
    if (a == 8'h08) m_grp = d[NGRP-1:0];
    else if (a >= 8'h10 && a < 8'h10 + 8'd200 && a[1:0] == 2'b00) begin
      b = (int'(a) - 16) / 40;
      r = ((int'(a) - 16) % 40) / 4;
      case (r)
        0: m_dir[b*32 +: 32] = d;
        1: m_out[b*32 +: 32] = d;
        2: m_out[b*32 +: 32] = m_out[b*32 +: 32] | d;
        3: m_out[b*32 +: 32] = m_out[b*32 +: 32] & ~d;
        5: m_rise[b*32 +: 32] = m_rise[b*32 +: 32] | d;
        6: m_rise[b*32 +: 32] = m_rise[b*32 +: 32] & ~d;
        7: m_fall[b*32 +: 32] = m_fall[b*32 +: 32] | d;
        8: m_fall[b*32 +: 32] = m_fall[b*32 +: 32] & ~d;
        9: m_stat[b*32 +: 32] = m_stat[b*32 +: 32] & ~d;
        default: ;
      endcase
    end
    m_stat = m_stat | ev;
  endfunction

  function automatic logic [31:0] mrd(logic [7:0] a);
    int b, r;
    if (a == 8'h08) return 32'(m_grp);
    if (a >= 8'h10 && a < 8'h10 + 8'd200 && a[1:0] == 2'b00) begin
      b = (int'(a) - 16) / 40;
      r = ((int'(a) - 16) % 40) / 4;
      case (r)
        0:       return m_dir[b*32 +: 32];
        1, 2, 3: return m_out[b*32 +: 32];
        4:       return m_pin[b*32 +: 32];
        5, 6:    return m_rise[b*32 +: 32];
        7, 8:    return m_fall[b*32 +: 32];
        default: return m_stat[b*32 +: 32];
      endcase
    end
    return 32'h0;
  endfunction

  // called at a negedge; the write commits at the following posedge
  task automatic wr_ev(logic [7:0] a, logic [31:0] d, logic [NPIN-1:0] ev);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; irq_evt = ev;
    @(negedge clk);
    bus_wr = 1'b0; irq_evt = '0;
    mwr(a, d, ev);
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    wr_ev(a, d, '0);
  endtask

  task automatic rd_chk(string req, logic [7:0] a);
    bus_rd = 1'b1; bus_addr = a;
    #1;
    chk(req, NPIN'(bus_rdata), NPIN'(mrd(a)));
    bus_rd = 1'b0;
  endtask

  task automatic ports_chk(string req);
    chk({req, " oe"},   pad_oe,   ~m_dir);
    chk({req, " out"},  pad_out,  m_out);
    chk({req, " rise"}, rise_en,  m_rise);
    chk({req, " fall"}, fall_en,  m_fall);
    chk({req, " stat"}, irq_stat, m_stat);
    chk({req, " grp"},  NPIN'(grp_en), NPIN'(m_grp));
  endtask

  initial begin
    #(CLK_P * 150000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int unsigned seed;
    logic [7:0] a;
    seed = $urandom(32'd4021);
    bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
    pad_in = '0; irq_evt = '0;
    m_dir = '1; m_out = '0; m_rise = '0; m_fall = '0; m_stat = '0; m_pin = '0; m_grp = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    ports_chk("R1");
    rd_chk("R1 dir0", 8'h10);
    rd_chk("R1 stat4", 8'hB0 + 8'h24);

    // R2 direction
    wr(8'h38, 32'h0000_FFFF);
    chk("R2 oe bank1", pad_oe, ~m_dir);
    rd_chk("R2 dir1", 8'h38);

    // R3 direct output write
    wr(8'h14, 32'hA5A5_3C3C);
    chk("R3 out", pad_out, m_out);
    rd_chk("R3 read", 8'h14);

    // R4 set, only ones act
    wr(8'h18, 32'h0000_00F0);
    chk("R4 out", pad_out, m_out);
    rd_chk("R4 read", 8'h18);

    // R5 clear, only ones act
    wr(8'h1C, 32'hA000_000C);
    chk("R5 out", pad_out, m_out);
    rd_chk("R5 read", 8'h1C);

    // R10 last bank maps to top pins
    wr(8'hB0 + 8'h04, 32'hDEAD_BEEF);
    chk("R10 bank4 out", {pad_out[159:128], 128'h0}, {32'hDEAD_BEEF, 128'h0});
    wr(8'h60 + 8'h08, 32'h8000_0001);
    chk("R10 bank2 out", pad_out, m_out);

    // R6 synchronizer: bank0 pins driven as outputs still read the pad
    wr(8'h10, 32'h0000_0000);
    pad_in = {NPIN{1'b0}} | {32'h1234_5678, 96'h0, 32'hCAFE_F00D};
    @(negedge clk);
    rd_chk("R6 one edge old", 8'h20);
    @(negedge clk);
    m_pin = pad_in;
    rd_chk("R6 two edges bank0", 8'h20);
    rd_chk("R6 two edges bank4", 8'hB0 + 8'h10);
    wr(8'h20, 32'hFFFF_FFFF);
    ports_chk("R6 in write inert");
    rd_chk("R6 in after write", 8'h20);

    // R7 rising enables
    wr(8'h24, 32'h0000_FF0F);
    wr(8'h28, 32'h0000_0F01);
    chk("R7 rise", rise_en, m_rise);
    rd_chk("R7 read clr", 8'h28);

    // R8 falling enables
    wr(8'h88 + 8'h1C, 32'hF0F0_0000);
    wr(8'h88 + 8'h20, 32'h1010_0000);
    chk("R8 fall", fall_en, m_fall);
    rd_chk("R8 read set", 8'h88 + 8'h1C);

    // R9 status
    irq_evt = NPIN'(160'h3) | (NPIN'(1) << 70);
    @(negedge clk);
    irq_evt = '0;
    m_stat = NPIN'(160'h3) | (NPIN'(1) << 70);
    chk("R9 evt set", irq_stat, m_stat);
    wr(8'h34, 32'h0000_0001);
    chk("R9 w1c", irq_stat, m_stat);
    wr_ev(8'h34, 32'h0000_0002, NPIN'(160'h2));
    chk("R9 evt beats clr", irq_stat, m_stat);
    rd_chk("R9 read", 8'h34);

    // R11 group enables
    wr(8'h08, 32'hFFFF_FFFF);
    chk("R11 grp", NPIN'(grp_en), NPIN'(10'h3FF));
    rd_chk("R11 read", 8'h08);

    // R12 holes
    rd_chk("R12 rd 0x00", 8'h00);
    rd_chk("R12 rd 0x0C", 8'h0C);
    rd_chk("R12 rd 0xD8", 8'hD8);
    rd_chk("R12 rd misaligned", 8'h11);
    wr(8'h0C, 32'hFFFF_FFFF);
    wr(8'hD8, 32'hFFFF_FFFF);
    wr(8'h15, 32'hFFFF_FFFF);
    ports_chk("R12 hole writes");

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [31:0] d;
      logic [NPIN-1:0] ev;
      d = $urandom;
      ev = '0;
      if (($urandom % 4) == 0) ev[$urandom % NPIN] = 1'b1;
      case ($urandom % 8)
        0:       a = 8'h08;
        1:       a = 8'($urandom % 256);
        default: a = 8'h10 + 8'(($urandom % 50) * 4);
      endcase
      wr_ev(a, d, ev);
      ports_chk("R10 random");
      rd_chk("R12 random read", a);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule